// File: doc/BRIEF.md
# Two-Port Semaphore Bank

This block holds a small set of hardware ownership flags that two independent agents, a left port and a right port, use to claim shared resources without a software lock. Each flag has three ownership states: free, held by the left side, or held by the right side. On top of that, each flag remembers whether the side that does not hold it is waiting. A port asks for a flag by writing a zero to it and gives it up by writing a one. A read tells the port whether it currently holds the flag.

A waiting request does not have to be repeated. When the holder lets go, the flag passes to the waiting side on that same clock edge. If both sides ask for a free flag in the same cycle, the left side wins and the right side is left waiting. Read data is captured into a per-port output register, so a write from the opposite side cannot disturb a value that has already been returned.

Access is synchronous. A port reaches the bank only in a cycle where its semaphore select is low and its memory chip enable is high. Only the low address bits that pick a flag are decoded.

Top module: `sem_bank_dp`

## Requirements
- R1: The bank holds eight flags, selected by the three least significant address bits. All higher address bits are ignored.
- R2: A port acts on the bank only in a cycle with `*_sel_n` low and `*_ce_n` high. In any other cycle its writes and reads have no effect, and its read register keeps its previous value.
- R3: A write is a cycle with `*_we_n` low. It uses only data bit 0: a 0 is a request and a 1 is a release or cancel. Data bits 7..1 are ignored.
- R4: A request to a free flag makes the requester the holder. From then on the holder reads 0 and the other port reads 1. A write from the non-holder never changes who holds the flag.
- R5: If the holder releases and the other side is not waiting, the flag becomes free and both ports read 1.
- R6: A request from the non-holder is remembered as waiting. When the holder releases, the waiting side becomes the holder at that same edge.
- R7: A read is a cycle with `*_we_n` high and `*_oe_n` low. At the closing edge it loads every bit of the port's read register with the flag value (0 if that port holds the flag, else 1). The register holds its value in all other cycles.
- R8: If both ports request the same free flag in the same cycle, the left port becomes the holder and the right request is recorded as waiting.
- R9: If a waiting port writes 1, its waiting request is cleared and the current holder is not affected.
- R10: After reset every flag is free with nothing waiting, and both read registers hold all ones.
- R11: A write takes effect at the closing edge of its cycle. A read made by the other port in that same cycle returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable, must be high for a semaphore access |
| l_addr | input | 12 | Left address, low 3 bits pick the flag |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wdata | input | 8 | Left write data, bit 0 used |
| l_rdata | output | 8 | Left read register |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable |
| r_addr | input | 12 | Right address |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read register |

## Verification
The assertions check several properties on every cycle:
- A waiting flag is always held by the opposite side.
- A holder keeps its flag until it writes a release.
- A release hands the flag to the waiting side, or frees it when no one waits.
- A left request to a free flag is granted.
- Cycles where neither port reaches the bank change no state.
- Read registers hold their value between reads and always carry a uniform value.

Some behaviour can only be shown by the bench's scenarios and its sweep over every pairing of port operations and flag addresses. This covers the values each port actually reads back, the left priority on same-cycle requests, cancelling a waiting request, ignoring upper address bits and upper data bits, and the old-state result of a read made in the same cycle as a write from the other side.

// File: rtl/sem_bank_pkg.sv
// Shared types for the two-port semaphore bank.
// Assumes: exactly two ports, called left and right.
package sem_bank_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
// Decodes one port's strobes into per-flag request and release pulses, plus a read
// enable and the index of the flag being read.
// Assumes: a port can access the bank only while its select is low and its chip enable is high.
module sem_port_dec #(
    parameter int N_SEM  = 8,
    parameter int ADDR_W = 12,
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(N_SEM)
) (
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DW-1:0]     wdata,
    output logic [N_SEM-1:0]  req,
    output logic [N_SEM-1:0]  rel,
    output logic              rd_en,
    output logic [IDX_W-1:0]  rd_idx
);
    logic             access;
    logic             wr;
    logic [IDX_W-1:0] idx;

    // Qualify the access and pick the flag index from the low address bits.
    always_comb begin
        access = !sel_n && ce_n;
        wr     = access && !we_n;
        rd_en  = access && we_n && !oe_n;
        idx    = addr[IDX_W-1:0];
        rd_idx = idx;
    end

    // One request/release pulse per flag; only data bit 0 picks which one.
    for (genvar i = 0; i < N_SEM; i++) begin : g_flag
        always_comb begin
            req[i] = wr && (idx == IDX_W'(i)) && !wdata[0];
            rel[i] = wr && (idx == IDX_W'(i)) &&  wdata[0];
        end
    end
endmodule

// File: rtl/sem_cell.sv
// State for one ownership flag: who holds it and whether the other side is waiting.
// Assumes: one port never requests and releases the same flag in one cycle. When both
// ports request a free flag in the same cycle, left wins.
module sem_cell
    import sem_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);
    owner_e owner_q, owner_d;
    logic   pl_q, pl_d, pr_q, pr_d;
    logic   pr_next, pl_next;

    // Next-state rules for grant, release, hand-off and waiting.
    always_comb begin
        owner_d = owner_q;
        pl_d    = 1'b0;
        pr_d    = 1'b0;
        pr_next = (pr_q || r_req) && !r_rel;
        pl_next = (pl_q || l_req) && !l_rel;
        case (owner_q)
            OWN_NONE: begin
                if (l_req) begin
                    owner_d = OWN_LEFT;
                    pr_d    = r_req;
                end else if (r_req) begin
                    owner_d = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                if (l_rel) owner_d = pr_next ? OWN_RIGHT : OWN_NONE;
                else       pr_d    = pr_next;
            end
            OWN_RIGHT: begin
                if (r_rel) owner_d = pl_next ? OWN_LEFT : OWN_NONE;
                else       pl_d    = pl_next;
            end
            default: owner_d = OWN_NONE;
        endcase
    end

    // Flag state register, cleared to free with nothing waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_NONE;
            pl_q    <= 1'b0;
            pr_q    <= 1'b0;
        end else begin
            owner_q <= owner_d;
            pl_q    <= pl_d;
            pr_q    <= pr_d;
        end
    end

    // Status outputs for the read path and the checker.
    always_comb begin
        own_l  = (owner_q == OWN_LEFT);
        own_r  = (owner_q == OWN_RIGHT);
        pend_l = pl_q;
        pend_r = pr_q;
    end
endmodule

// File: rtl/sem_read_reg.sv
// Per-port read register. On a read it captures the selected flag's value on every bit
// and holds it until the next read.
// Assumes: own[i] is high when this port holds flag i.
module sem_read_reg #(
    parameter int N_SEM  = 8,
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(N_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [N_SEM-1:0] own,
    output logic [DW-1:0]    rdata
);
    logic val;

    // Flag value as this port sees it: 0 when held by this port.
    always_comb val = !own[rd_idx];

    // Capture on a read, hold otherwise; reset to all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '1;
        else if (rd_en) rdata <= {DW{val}};
    end
endmodule

// File: rtl/sem_bank_dp.sv
// Top level of the two-port semaphore bank: two port decoders, one state cell per flag,
// and one read register per port.
// Assumes: synchronous ports sharing one clock; the memory array is outside this block.
module sem_bank_dp #(
    parameter int N_SEM  = 8,
    parameter int ADDR_W = 12,
    parameter int DW     = 8,
    localparam int IDX_W = $clog2(N_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [DW-1:0]     l_wdata,
    output logic [DW-1:0]     l_rdata,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [DW-1:0]     r_wdata,
    output logic [DW-1:0]     r_rdata
);
    logic [N_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [N_SEM-1:0] own_l, own_r, pend_l, pend_r;
    logic             l_rd_en, r_rd_en;
    logic [IDX_W-1:0] l_rd_idx, r_rd_idx;

    sem_port_dec #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DW(DW)) u_dec_l (
        .sel_n(l_sel_n), .ce_n(l_ce_n), .addr(l_addr), .we_n(l_we_n), .oe_n(l_oe_n),
        .wdata(l_wdata), .req(l_req), .rel(l_rel), .rd_en(l_rd_en), .rd_idx(l_rd_idx)
    );

    sem_port_dec #(.N_SEM(N_SEM), .ADDR_W(ADDR_W), .DW(DW)) u_dec_r (
        .sel_n(r_sel_n), .ce_n(r_ce_n), .addr(r_addr), .we_n(r_we_n), .oe_n(r_oe_n),
        .wdata(r_wdata), .req(r_req), .rel(r_rel), .rd_en(r_rd_en), .rd_idx(r_rd_idx)
    );

    for (genvar i = 0; i < N_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[i]), .l_rel(l_rel[i]), .r_req(r_req[i]), .r_rel(r_rel[i]),
            .own_l(own_l[i]), .own_r(own_r[i]), .pend_l(pend_l[i]), .pend_r(pend_r[i])
        );
    end

    sem_read_reg #(.N_SEM(N_SEM), .DW(DW)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd_en), .rd_idx(l_rd_idx), .own(own_l), .rdata(l_rdata)
    );

    sem_read_reg #(.N_SEM(N_SEM), .DW(DW)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd_en), .rd_idx(r_rd_idx), .own(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sem_bank_dp_chk.sv
// Property checker for the semaphore bank, attached to every instance by bind.
// Assumes: it sees the top level's decoded pulses and the state of each cell.
module sem_bank_dp_chk #(
    parameter int N_SEM = 8,
    parameter int DW    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             l_sel_n, l_ce_n, l_we_n, l_oe_n,
    input logic             r_sel_n, r_ce_n, r_we_n, r_oe_n,
    input logic [DW-1:0]    l_rdata,
    input logic [DW-1:0]    r_rdata,
    input logic [N_SEM-1:0] l_req, l_rel, r_req, r_rel,
    input logic [N_SEM-1:0] own_l, own_r, pend_l, pend_r
);
    logic l_rd, r_rd, idle;

    // Port-level read and idle conditions, rebuilt from the pins.
    always_comb begin
        l_rd = !l_sel_n && l_ce_n && l_we_n && !l_oe_n;
        r_rd = !r_sel_n && r_ce_n && r_we_n && !r_oe_n;
        idle = (l_sel_n || !l_ce_n) && (r_sel_n || !r_ce_n);
    end

    for (genvar i = 0; i < N_SEM; i++) begin : g_chk
        AST_PEND_R_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            pend_r[i] |-> own_l[i]); // R6
        AST_PEND_L_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
            pend_l[i] |-> own_r[i]); // R6
        AST_FREE_GRANT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
            (!own_l[i] && !own_r[i] && l_req[i]) |=> own_l[i]); // R8
        AST_HOLDER_KEEPS_L: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && !l_rel[i]) |=> own_l[i]); // R4
        AST_HOLDER_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
            (own_r[i] && !r_rel[i]) |=> own_r[i]); // R4
        AST_HANDOFF_TO_R: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && pend_r[i] && l_rel[i] && !r_rel[i]) |=> own_r[i]); // R6
        AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
            (own_l[i] && !pend_r[i] && !r_req[i] && l_rel[i]) |=> (!own_l[i] && !own_r[i])); // R5
    end

    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> ($stable(own_l) && $stable(own_r) && $stable(pend_l) && $stable(pend_r))); // R2
    AST_RDATA_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata)); // R7
    AST_RDATA_HOLD_R: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata)); // R7
    AST_RDATA_UNIFORM_L: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rdata == '0) || (l_rdata == '1)); // R7
    AST_RDATA_UNIFORM_R: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rdata == '0) || (r_rdata == '1)); // R7
endmodule

bind sem_bank_dp sem_bank_dp_chk #(.N_SEM(N_SEM), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .l_rdata(l_rdata), .r_rdata(r_rdata),
    .l_req(l_req), .l_rel(l_rel), .r_req(r_req), .r_rel(r_rel),
    .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_bank_dp_bench.sv
`timescale 1ns/1ps
module sem_bank_dp_bench;
    localparam int N  = 8;
    localparam int AW = 12;
    localparam int DW = 8;

    // Port operation codes used by the bench
    localparam int OP_IDLE = 0; // select high
    localparam int OP_REQ  = 1; // write, data 8'hFE (bit0 = 0)
    localparam int OP_REL  = 2; // write, data 8'h01 (bit0 = 1)
    localparam int OP_RD   = 3; // read
    localparam int OP_BWR  = 4; // write with chip enable low: blocked
    localparam int OP_BRD  = 5; // read with chip enable low: blocked
    localparam int OP_NOP  = 6; // selected, no strobe

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_sel_n, l_ce_n, l_we_n, l_oe_n, r_sel_n, r_ce_n, r_we_n, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model: 0 free, 1 left holds, 2 right holds
    int m_own [N];
    bit m_pl  [N];
    bit m_pr  [N];
    logic [DW-1:0] exp_l, exp_r;

    always #2 clk = ~clk;

    sem_bank_dp u_sem_bank_dp (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n),
        .l_oe_n(l_oe_n), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n),
        .r_oe_n(r_oe_n), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic logic [11:0] enc(input int op);
        case (op)
            OP_REQ:  return {4'b0101, 8'hFE};
            OP_REL:  return {4'b0101, 8'h01};
            OP_RD:   return {4'b0110, 8'h00};
            OP_BWR:  return {4'b0001, 8'h00};
            OP_BRD:  return {4'b0010, 8'h00};
            OP_NOP:  return {4'b0111, 8'h00};
            default: return {4'b1111, 8'h00};
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of operations on both ports, update the model, compare both read registers.
    task automatic do_cycle(input int opl, input logic [AW-1:0] al,
                            input int opr, input logic [AW-1:0] ar, input string tag);
        logic [11:0] el, er;
        int il, ir;
        bit lq, ll, rq, rl, prn, pln;
        el = enc(opl);
        er = enc(opr);
        il = int'(al[2:0]);
        ir = int'(ar[2:0]);
        @(negedge clk);
        {l_sel_n, l_ce_n, l_we_n, l_oe_n, l_wdata} = el;
        {r_sel_n, r_ce_n, r_we_n, r_oe_n, r_wdata} = er;
        l_addr = al;
        r_addr = ar;
        if (opl == OP_RD) exp_l = (m_own[il] == 1) ? '0 : '1;
        if (opr == OP_RD) exp_r = (m_own[ir] == 2) ? '0 : '1;
        for (int i = 0; i < N; i++) begin
            lq = (opl == OP_REQ) && (il == i);
            ll = (opl == OP_REL) && (il == i);
            rq = (opr == OP_REQ) && (ir == i);
            rl = (opr == OP_REL) && (ir == i);
            prn = (m_pr[i] || rq) && !rl;
            pln = (m_pl[i] || lq) && !ll;
            if (m_own[i] == 0) begin
                if (lq) begin m_own[i] = 1; m_pr[i] = rq; end
                else if (rq) m_own[i] = 2;
            end else if (m_own[i] == 1) begin
                if (ll) begin m_own[i] = prn ? 2 : 0; m_pr[i] = 1'b0; end
                else m_pr[i] = prn;
            end else begin
                if (rl) begin m_own[i] = pln ? 1 : 0; m_pl[i] = 1'b0; end
                else m_pl[i] = pln;
            end
        end
        @(posedge clk);
        #1;
        check({tag, " left"}, l_rdata, exp_l);
        check({tag, " right"}, r_rdata, exp_r);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_own[i] = 0; m_pl[i] = 0; m_pr[i] = 0; end
        exp_l = '1;
        exp_r = '1;
        {l_sel_n, l_ce_n, l_we_n, l_oe_n, l_wdata} = enc(OP_IDLE);
        {r_sel_n, r_ce_n, r_we_n, r_oe_n, r_wdata} = enc(OP_IDLE);
        l_addr = '0;
        r_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", l_rdata, '1);
        check("R10 reset", r_rdata, '1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) do_cycle(OP_RD, 12'(i), OP_RD, 12'(i), "R10");
        // R4: grant and non-holder writes ignored
        do_cycle(OP_REQ, 12'd3, OP_IDLE, 12'd0, "R4");
        do_cycle(OP_RD, 12'd3, OP_RD, 12'd3, "R4");
        do_cycle(OP_IDLE, 12'd0, OP_REL, 12'd3, "R4");
        do_cycle(OP_RD, 12'd3, OP_RD, 12'd3, "R4");
        // R6: waiting side takes over on release
        do_cycle(OP_IDLE, 12'd0, OP_REQ, 12'd3, "R6");
        do_cycle(OP_REL, 12'd3, OP_IDLE, 12'd0, "R6");
        do_cycle(OP_RD, 12'd3, OP_RD, 12'd3, "R6");
        // R9: cancel a waiting request
        do_cycle(OP_REQ, 12'd3, OP_IDLE, 12'd0, "R9");
        do_cycle(OP_REL, 12'd3, OP_RD, 12'd3, "R9");
        do_cycle(OP_IDLE, 12'd0, OP_REL, 12'd3, "R9");
        do_cycle(OP_RD, 12'd3, OP_RD, 12'd3, "R9");
        // R5: release with nobody waiting
        do_cycle(OP_REQ, 12'd5, OP_IDLE, 12'd0, "R5");
        do_cycle(OP_REL, 12'd5, OP_IDLE, 12'd0, "R5");
        do_cycle(OP_RD, 12'd5, OP_RD, 12'd5, "R5");
        // R8: same-cycle requests, left wins
        do_cycle(OP_REQ, 12'd6, OP_REQ, 12'd6, "R8");
        do_cycle(OP_RD, 12'd6, OP_RD, 12'd6, "R8");
        do_cycle(OP_REL, 12'd6, OP_IDLE, 12'd0, "R8");
        do_cycle(OP_RD, 12'd6, OP_RD, 12'd6, "R8");
        do_cycle(OP_IDLE, 12'd0, OP_REL, 12'd6, "R8");
        // R1 and R3: upper address bits and upper data bits ignored
        do_cycle(OP_REQ, 12'hFF2, OP_IDLE, 12'd0, "R1");
        do_cycle(OP_RD, 12'hA02, OP_RD, 12'h5FA, "R1");
        do_cycle(OP_RD, 12'h002, OP_RD, 12'h002, "R3");
        // R11: read in the same cycle as a hand-off sees the old state
        do_cycle(OP_IDLE, 12'd0, OP_REQ, 12'd2, "R11");
        do_cycle(OP_REL, 12'd2, OP_RD, 12'd2, "R11");
        do_cycle(OP_IDLE, 12'd0, OP_RD, 12'd2, "R11");
        do_cycle(OP_IDLE, 12'd0, OP_REL, 12'd2, "R11");
        // R2: blocked accesses change nothing and do not load the read register
        do_cycle(OP_RD, 12'd0, OP_RD, 12'd0, "R2");
        do_cycle(OP_BWR, 12'd0, OP_BWR, 12'd0, "R2");
        do_cycle(OP_NOP, 12'd0, OP_NOP, 12'd0, "R2");
        do_cycle(OP_REQ, 12'd1, OP_IDLE, 12'd0, "R2");
        do_cycle(OP_BRD, 12'd1, OP_BRD, 12'd1, "R2");
        do_cycle(OP_RD, 12'd0, OP_RD, 12'd0, "R2");
        do_cycle(OP_RD, 12'd1, OP_RD, 12'd1, "R2");
        // R7: sweep every pairing of operations and flag addresses
        for (int ol = 0; ol < 7; ol++)
            for (int orr = 0; orr < 7; orr++)
                for (int al = 0; al < N; al++)
                    for (int ar = 0; ar < N; ar++)
                        do_cycle(ol, 12'(al + 8 * ol), orr, 12'(ar + 16 * orr), "R7 sweep");
        for (int i = 0; i < N; i++) do_cycle(OP_RD, 12'(i), OP_RD, 12'(i), "R7 final");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule